// File: doc/BRIEF.md
# Voice-Coil DAC Command Slave on a Two-Wire Bus

This block is the digital front end of a current-sink actuator driver. It listens on an I2C bus, oversampling SCL and SDA with a fast system clock. It removes short spikes from both lines and finds start and stop conditions. It answers to one fixed 7-bit device address. A write carries two data bytes that together form a 16-bit command word. Once the second byte has arrived, the block moves three things to the analog side in a single clock: a soft power-down flag, a 10-bit target code and a 4-bit slope-mode field.

A read returns the last received command word, high byte first. Every read transaction leaves that word cleared to zero. A hard-shutdown pin of selectable polarity turns the output enable off at once, with no clock involved, and leaves every stored value as it was. The block does not stretch the clock. SDA is driven only by pulling it low, through `sda_oe_o`.

Top module: `actdac_i2c_slave`

## Requirements
- R1: Only the address bytes 0x18 (write) and 0x19 (read), that is the 7-bit address 0001100 plus a read/write bit, get an acknowledge. Any other address is not acknowledged, and the bytes that follow it change nothing.
- R2: The slave acknowledges the address byte and both data bytes of a write by holding SDA low through the ninth SCL pulse. A third data byte in the same write is not acknowledged.
- R3: Command word layout, sent high byte first and MSB first: bit 15 is the soft power-down flag, bits 13:4 are the DAC code and bits 3:0 are the slope mode. All three outputs update together, once, after the eighth bit of the second data byte.
- R4: A frame whose bit 14 is 0 is still acknowledged but is not committed. The outputs keep their previous values.
- R5: A stop that arrives before the second data byte is complete discards the partial frame. The outputs keep their previous values.
- R6: A read sends the stored 16-bit word as two bytes, high byte first and MSB first, changing SDA only while SCL is low. After the master's NACK the slave leaves SDA released.
- R7: The stop or repeated start that ends a read transaction clears the stored word, so the next read returns 0x0000.
- R8: A pulse on SCL or SDA shorter than FILT_CYC system clocks (5 by default) has no effect on the bus logic. A 3-clock SDA spike while SCL is high does not abort a write.
- R9: After reset the code, the slope and the power-down flag are all zero, and the output enable is high.
- R10: While `shdn_i` is at its active level (low when SHDN_ACTIVE_HIGH is 0, which is the default), `out_en_o` is low within the same cycle. Code and slope are unaffected.
- R11: While the committed power-down flag is 1, `out_en_o` is low, and a later frame with the flag at 0 enables the output at that frame's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| shdn_i | input | 1 | Hard-shutdown pin, polarity set by SHDN_ACTIVE_HIGH |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| dac_code_o | output | 10 | Committed DAC target code |
| slope_o | output | 4 | Committed slope mode |
| soft_pd_o | output | 1 | Committed soft power-down flag |
| out_en_o | output | 1 | Output stage enable |

## Verification
The bench aims spikes at SDA while SCL is high. An unfiltered design would see a false start and stop and drop the frame. It sends frames with bit 14 cleared, a frame addressed to a neighbour, and a write cut short after one byte. A design that commits too early or without checking would then show a changed code on the every-clock comparison. Two reads in a row expose a register that is not cleared after a read, and a read issued after a rejected frame checks that the input register still holds that frame. A third data byte that gets an acknowledge, and a shutdown pin that acts only through a flip-flop, are both caught at the pins.

// File: rtl/actdac_pkg.sv
package actdac_pkg;
  localparam int FRAME_W = 16;
  localparam int CODE_W  = 10;
  localparam int SLOPE_W = 4;
  localparam int BYTE_W  = 8;
  localparam int PD_BIT  = 15;
  localparam int KEY_BIT = 14;
  localparam int CODE_LSB = SLOPE_W;
  localparam int KEY_IN_HI = KEY_BIT - BYTE_W;

  typedef enum logic [2:0] {
    LK_IDLE, LK_ADDR, LK_AACK, LK_WBYTE, LK_WACK, LK_RBYTE, LK_RACK, LK_SKIP
  } link_st_t;

  typedef struct packed {
    logic               pd;
    logic [CODE_W-1:0]  code;
    logic [SLOPE_W-1:0] slope;
  } cmd_t;
endpackage

// File: rtl/actdac_glitch_filter.sv
module actdac_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      run_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (synced == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_CYC - 1)) begin
        dout  <= synced;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/actdac_bus_events.sv
module actdac_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    start_p = scl_q && scl && sda_q && !sda;
    stop_p  = scl_q && scl && !sda_q && sda;
    rise_p  = !scl_q && scl;
    fall_p  = scl_q && !scl;
  end
endmodule

// File: rtl/actdac_link_fsm.sv
module actdac_link_fsm
  import actdac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h0C
) (
  input  logic clk,
  input  logic rst,
  input  logic start_p,
  input  logic stop_p,
  input  logic rise_p,
  input  logic fall_p,
  input  logic sda_f,
  output logic sda_oe_o,
  output logic cmd_vld_o,
  output cmd_t cmd_o
);
  link_st_t            st_q;
  logic [3:0]          bit_q;
  logic [BYTE_W-1:0]   sh_q, hi_q, tx_q, nxt_tx;
  logic [FRAME_W-1:0]  inreg_q;
  logic                byte_q, rd_q;

  assign nxt_tx = byte_q ? '0 : inreg_q[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= LK_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      hi_q      <= '0;
      tx_q      <= '0;
      inreg_q   <= '0;
      byte_q    <= 1'b0;
      rd_q      <= 1'b0;
      sda_oe_o  <= 1'b0;
      cmd_vld_o <= 1'b0;
      cmd_o     <= '0;
    end else begin
      cmd_vld_o <= 1'b0;
      if (start_p || stop_p) begin
        if (rd_q) inreg_q <= '0;
        rd_q     <= 1'b0;
        sda_oe_o <= 1'b0;
        bit_q    <= '0;
        byte_q   <= 1'b0;
        st_q     <= start_p ? LK_ADDR : LK_IDLE;
      end else begin
        case (st_q)
          LK_ADDR, LK_WBYTE: begin
            if (rise_p && bit_q != 4'd8) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
              bit_q <= bit_q + 1'b1;
            end else if (fall_p && bit_q == 4'd8) begin
              bit_q <= '0;
              if (st_q == LK_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  sda_oe_o <= 1'b1;
                  rd_q     <= sh_q[0];
                  st_q     <= LK_AACK;
                end else begin
                  st_q <= LK_SKIP;
                end
              end else begin
                sda_oe_o <= 1'b1;
                st_q     <= LK_WACK;
                if (!byte_q) begin
                  hi_q <= sh_q;
                end else begin
                  inreg_q <= {hi_q, sh_q};
                  if (hi_q[KEY_IN_HI]) begin
                    cmd_vld_o   <= 1'b1;
                    cmd_o.pd    <= hi_q[PD_BIT-BYTE_W];
                    cmd_o.code  <= {hi_q[CODE_W-BYTE_W+CODE_LSB-1:0], sh_q[BYTE_W-1:CODE_LSB]};
                    cmd_o.slope <= sh_q[SLOPE_W-1:0];
                  end
                end
              end
            end
          end
          LK_AACK: begin
            if (fall_p) begin
              byte_q <= 1'b0;
              if (rd_q) begin
                tx_q     <= inreg_q[FRAME_W-1:BYTE_W];
                sda_oe_o <= !inreg_q[FRAME_W-1];
                st_q     <= LK_RBYTE;
              end else begin
                sda_oe_o <= 1'b0;
                st_q     <= LK_WBYTE;
              end
            end
          end
          LK_WACK: begin
            if (fall_p) begin
              sda_oe_o <= 1'b0;
              if (!byte_q) begin
                byte_q <= 1'b1;
                st_q   <= LK_WBYTE;
              end else begin
                st_q <= LK_SKIP;
              end
            end
          end
          LK_RBYTE: begin
            if (rise_p) begin
              bit_q <= bit_q + 1'b1;
            end else if (fall_p) begin
              if (bit_q == 4'd8) begin
                bit_q    <= '0;
                sda_oe_o <= 1'b0;
                st_q     <= LK_RACK;
              end else begin
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= !tx_q[BYTE_W-2];
              end
            end
          end
          LK_RACK: begin
            if (rise_p) begin
              if (sda_f) st_q <= LK_SKIP;
              else       bit_q <= 4'd1;
            end else if (fall_p && bit_q == 4'd1) begin
              bit_q    <= '0;
              tx_q     <= nxt_tx;
              sda_oe_o <= !nxt_tx[BYTE_W-1];
              byte_q   <= 1'b1;
              st_q     <= LK_RBYTE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/actdac_i2c_slave.sv
module actdac_i2c_slave
  import actdac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h0C,
  parameter int FILT_CYC         = 5,
  parameter int SYNC_STAGES      = 2,
  parameter bit SHDN_ACTIVE_HIGH = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               shdn_i,
  output logic               sda_oe_o,
  output logic [CODE_W-1:0]  dac_code_o,
  output logic [SLOPE_W-1:0] slope_o,
  output logic               soft_pd_o,
  output logic               out_en_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_w, filt_w;
  logic start_p, stop_p, rise_p, fall_p;
  logic cmd_vld;
  cmd_t cmd_new, cmd_q;
  logic shdn_act;

  assign raw_w = {sda_i, scl_i};

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    actdac_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_w[gi]),
      .dout(filt_w[gi])
    );
  end

  actdac_bus_events u_events (
    .clk    (clk),
    .rst    (rst),
    .scl    (filt_w[0]),
    .sda    (filt_w[1]),
    .start_p(start_p),
    .stop_p (stop_p),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  actdac_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk      (clk),
    .rst      (rst),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .sda_f    (filt_w[1]),
    .sda_oe_o (sda_oe_o),
    .cmd_vld_o(cmd_vld),
    .cmd_o    (cmd_new)
  );

  always_ff @(posedge clk) begin
    if (rst)          cmd_q <= '0;
    else if (cmd_vld) cmd_q <= cmd_new;
  end

  if (SHDN_ACTIVE_HIGH) begin : g_shdn_hi
    assign shdn_act = shdn_i;
  end else begin : g_shdn_lo
    assign shdn_act = !shdn_i;
  end

  assign dac_code_o = cmd_q.code;
  assign slope_o    = cmd_q.slope;
  assign soft_pd_o  = cmd_q.pd;
  assign out_en_o   = !cmd_q.pd && !shdn_act;
endmodule

// File: rtl/actdac_i2c_slave_chk.sv
module actdac_i2c_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic [9:0] dac_code_o,
  input logic [3:0] slope_o,
  input logic       soft_pd_o
);
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dac_code_o == '0 && slope_o == '0 && !soft_pd_o));

  assert_commit_in_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(dac_code_o) || !$stable(slope_o) || !$stable(soft_pd_o)) |-> sda_oe_o);

  assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_i);

  assert_release_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe_o) |-> !scl_i);
endmodule

bind actdac_i2c_slave actdac_i2c_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .dac_code_o(dac_code_o),
  .slope_o   (slope_o),
  .soft_pd_o (soft_pd_o)
);

// File: tb/test_actdac_i2c_slave.sv
module test_actdac_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1, shdn_drv = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [9:0] dac_code;
  logic [3:0] slope;
  logic soft_pd, out_en;

  int checks = 0, errors = 0;
  logic flux = 1'b0;
  logic [9:0] exp_code = '0;
  logic [3:0] exp_slope = '0;
  logic exp_pd = 1'b0;
  logic [15:0] exp_word = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_drv & ~sda_oe;

  actdac_i2c_slave i_actdac_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_bus), .shdn_i(shdn_drv),
    .sda_oe_o(sda_oe), .dac_code_o(dac_code), .slope_o(slope),
    .soft_pd_o(soft_pd), .out_en_o(out_en)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model compared on every clock (R3, R10, R11)
  always @(negedge clk) begin
    if (!rst && !flux && !done) begin
      chk("R3 code", dac_code, exp_code);
      chk("R3 slope", slope, exp_slope);
      chk("R11 pd", soft_pd, exp_pd);
      chk("R10/R11 out_en", out_en, (!exp_pd && shdn_drv) ? 1 : 0);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic bus_start;
    sda_drv = 1; scl_drv = 1; tick(H); sda_drv = 0; tick(H); scl_drv = 0; tick(H);
  endtask
  task automatic bus_stop;
    sda_drv = 0; tick(H); scl_drv = 1; tick(H); sda_drv = 1; tick(H);
  endtask
  task automatic put_bit(logic b);
    sda_drv = b; tick(H); scl_drv = 1; tick(H); scl_drv = 0;
  endtask
  task automatic put_bit_spiked;
    sda_drv = 1; tick(H); scl_drv = 1; tick(H/4);
    sda_drv = 0; tick(3); sda_drv = 1;
    tick(H - H/4 - 3); scl_drv = 0;
  endtask
  task automatic get_bit(output logic b);
    sda_drv = 1; tick(H); scl_drv = 1; tick(H/2); b = sda_bus; tick(H - H/2); scl_drv = 0;
  endtask
  task automatic put_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask
  task automatic get_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
  endtask

  task automatic commit_model(logic [7:0] hi, logic [7:0] lo, bit addressed);
    flux = 1;
    if (addressed) begin
      exp_word = {hi, lo};
      if (hi[6]) begin
        exp_pd = hi[7];
        exp_code = {hi[5:0], lo[7:4]};
        exp_slope = lo[3:0];
      end
    end
    tick(20);
    flux = 0;
  endtask

  task automatic wr_frame(logic [7:0] a, logic [7:0] hi, logic [7:0] lo, bit extra, string tag);
    logic ack;
    bit addressed;
    addressed = (a == 8'h18);
    bus_start;
    put_byte(a); get_bit(ack);
    chk({tag, " R1 addr ack"}, ack, addressed ? 0 : 1);
    put_byte(hi); get_bit(ack);
    chk({tag, " R2 byte1 ack"}, ack, addressed ? 0 : 1);
    put_byte(lo);
    commit_model(hi, lo, addressed);
    get_bit(ack);
    chk({tag, " R2 byte2 ack"}, ack, addressed ? 0 : 1);
    if (extra) begin
      put_byte(8'hAA); get_bit(ack);
      chk({tag, " R2 third byte nack"}, ack, 1);
    end
    bus_stop;
  endtask

  task automatic rd_frame(string tag);
    logic ack;
    logic [7:0] b0, b1;
    bus_start;
    put_byte(8'h19); get_bit(ack);
    chk({tag, " R1 read addr ack"}, ack, 0);
    get_byte(b0); put_bit(0);
    get_byte(b1); put_bit(1);
    chk({tag, " R6 high byte"}, b0, exp_word[15:8]);
    chk({tag, " R6 low byte"}, b1, exp_word[7:0]);
    sda_drv = 1; tick(H/2);
    chk({tag, " R6 released after nack"}, sda_bus, 1);
    bus_stop;
    exp_word = '0;
  endtask

  initial begin : main
    logic ack;
    tick(5);
    rst = 0;
    tick(2);
    chk("R9 reset code", dac_code, 0);
    chk("R9 reset slope", slope, 0);
    chk("R9 reset pd", soft_pd, 0);
    chk("R9 reset out_en", out_en, 1);
    chk("R9 reset sda_oe", sda_oe, 0);

    wr_frame(8'h18, 8'h4A, 8'hB5, 0, "R3 basic");
    chk("R3 code 0AB", dac_code, 10'h0AB);
    wr_frame(8'h18, 8'hC0, 8'h12, 0, "R11 pd on");
    chk("R11 out_en low in pd", out_en, 0);
    wr_frame(8'h18, 8'h40, 8'h30, 0, "R11 pd off");
    chk("R11 out_en back", out_en, 1);
    chk("R11 code after pd", dac_code, 3);

    shdn_drv = 0;
    @(negedge clk);
    chk("R10 shutdown same cycle", out_en, 0);
    chk("R10 code kept", dac_code, 3);
    tick(4);
    shdn_drv = 1;
    tick(2);

    wr_frame(8'h18, 8'h3F, 8'hFF, 0, "R4 key bit zero");
    chk("R4 code unchanged", dac_code, 3);
    wr_frame(8'h1A, 8'h7F, 8'hFF, 0, "R1 foreign addr");
    chk("R1 code unchanged", dac_code, 3);

    bus_start;
    put_byte(8'h18); get_bit(ack);
    chk("R5 addr ack", ack, 0);
    put_byte(8'h7F); get_bit(ack);
    chk("R5 byte1 ack", ack, 0);
    bus_stop;
    tick(10);
    chk("R5 code unchanged", dac_code, 3);

    rd_frame("R6 first read");
    rd_frame("R7 second read");

    bus_start;
    put_byte(8'h18); get_bit(ack);
    put_bit(0); put_bit_spiked;
    for (int i = 5; i >= 0; i--) put_bit(logic'((8'h5C >> i) & 1));
    get_bit(ack);
    chk("R8 ack after spike", ack, 0);
    put_byte(8'h3E);
    commit_model(8'h5C, 8'h3E, 1);
    get_bit(ack);
    bus_stop;
    chk("R8 spiked frame committed", dac_code, 10'h1C3);

    wr_frame(8'h18, 8'h7F, 8'hFF, 1, "R2 full scale");
    chk("R3 full scale code", dac_code, 10'h3FF);
    chk("R3 full scale slope", slope, 4'hF);

    tick(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule